// File: doc/BRIEF.md
# Carrier-Rate Clock Divider with 8 kHz Frame Pulse

This block runs entirely on one fast reference clock, the higher-rate synthesized clock of a carrier-rate converter. From it, the block derives a lower carrier-rate clock by integer division. It also derives a frame pulse that repeats at 8 kHz and is locked to both clocks. A carrier-select bit and four program bits choose an operating row. That row fixes the divide ratio, the number of divided-clock cycles in one frame, and the width of the frame pulse. A polarity bit sets the active level of the frame pulse and of the external sync input.

An optional external frame sync can re-phase the block. It may arrive at 8 kHz or at any integer subrate. The input is first passed through a synchronizer. Each active edge then restarts the divider and the frame counter, so that both clocks and the frame pulse take a fixed alignment at the frame boundary. If the input is held at a constant level, the block runs freely. A change of mode restarts both counters at phase zero, so no runt divided-clock pulse can appear.

Top module: `frame_sync_divider`

## Requirements
- R1: While `rstN` is low, both counters sit at phase zero of frame zero: `divClk` reads 1 and `frameSync` shows its active level.
- R2: The divide ratio N is the fast-clock cycles per divided-clock cycle. `divClk` is high for the first ceil(N/2) fast cycles of each group of N. For carrierSel=0, N is 3 on program values 0,2,4,6,8,10,12,14; 4 on 1,3,7; and 2 on 5,9,11,13,15. For carrierSel=1, N is 2 on 0,1,5,8,9,10,13; 4 on 2,3,7,11,15; and 5 on 4,6,12,14. The program value is `progBits` read as an unsigned number.
- R3: A frame lasts L divided-clock cycles, so the frame pulse repeats every N*L fast cycles. L is the divided rate over 8 kHz. With carrierSel=0, L is 320 on program values 4,6,12,14; 512 on 5,9,11,13,15; and 256 on all other values. With carrierSel=1, L is 386 wherever N is 2 and 193 wherever N is 4 or 5.
- R4: The pulse is short only for carrierSel=0 with program value 1, 3 or 7. Every other row, including every carrierSel=1 row, uses a long pulse.
- R5: The pulse starts on the first fast cycle of frame zero. A long pulse lasts N fast cycles, one divided-clock period. A short pulse lasts N/2 fast cycles.
- R6: With `syncPol`=0, `frameSync` is active high and `extSync` is active on its high level. With `syncPol`=1, both are active low.
- R7: Suppose `extSync` turns active before fast-clock edge k, and it was inactive as seen at the previous edge. Then after edge k+2 both counters are at phase zero of frame zero.
- R8: A level of `extSync` held for any number of cycles causes at most one realignment, at its leading active edge. Holding the inactive level leaves the counters free-running. Every later active edge, whatever its spacing, realigns again.
- R9: If `{carrierSel, progBits}` differs from the value sampled at the previous edge, the next edge puts both counters at phase zero of frame zero. Counting then proceeds in the new mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fastClk | input | 1 | Fast reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| carrierSel | input | 1 | 0: outputs at E-carrier rates, 1: outputs at T-carrier rates |
| progBits | input | 4 | Row select within the chosen carrier table |
| syncPol | input | 1 | Active level of frameSync and extSync (0 high, 1 low) |
| extSync | input | 1 | External frame sync, asynchronous |
| divClk | output | 1 | Divided carrier-rate clock |
| frameSync | output | 1 | 8 kHz frame pulse |

## Verification
The bench goes after odd ratios, the short pulse at N=4 and the extremes of frame length (193 and 512). A wrong reload value there would stretch or shrink the 8 kHz period, and a wrong half-period would mis-size the high time or the pulse. External sync is held active for thousands of cycles. A level-triggered design would keep the counters pinned at zero, and the frame pulse would never repeat. Modes and pulses then change at random instants, including mid-frame, and alongside them the three-edge realign latency is measured directly. An off-by-one synchronizer, or a mode change that failed to restart the counters, would shift every later edge against the reference model.

// File: rtl/fsd_pkg.sv
package fsd_pkg;
  parameter int PHASE_W = 3;
  parameter int FRAME_W = 10;
  parameter int MODE_W  = 5;

  typedef struct packed {
    logic [PHASE_W-1:0] ratio;
    logic [FRAME_W-1:0] frameLen;
    logic               shortPulse;
  } modeCfgT;

  typedef struct packed {
    logic realign;
    logic restart;
  } strobeT;

  // Row decode: bit 4 is the carrier select, bits 3:0 the program value.
  function automatic modeCfgT decodeMode(input logic [MODE_W-1:0] m);
    modeCfgT c;
    c.shortPulse = 1'b0;
    c.ratio      = PHASE_W'(3);
    c.frameLen   = FRAME_W'(256);
    if (!m[4]) begin
      case (m[3:0])
        4'd1, 4'd3, 4'd7: begin
          c.ratio = PHASE_W'(4); c.frameLen = FRAME_W'(256); c.shortPulse = 1'b1;
        end
        4'd4, 4'd6, 4'd12, 4'd14: begin
          c.ratio = PHASE_W'(3); c.frameLen = FRAME_W'(320);
        end
        4'd5, 4'd9, 4'd11, 4'd13, 4'd15: begin
          c.ratio = PHASE_W'(2); c.frameLen = FRAME_W'(512);
        end
        default: begin
          c.ratio = PHASE_W'(3); c.frameLen = FRAME_W'(256);
        end
      endcase
    end else begin
      case (m[3:0])
        4'd4, 4'd6, 4'd12, 4'd14: begin
          c.ratio = PHASE_W'(5); c.frameLen = FRAME_W'(193);
        end
        4'd2, 4'd3, 4'd7, 4'd11, 4'd15: begin
          c.ratio = PHASE_W'(4); c.frameLen = FRAME_W'(193);
        end
        default: begin
          c.ratio = PHASE_W'(2); c.frameLen = FRAME_W'(386);
        end
      endcase
    end
    return c;
  endfunction
endpackage

// File: rtl/fsd_sync_chain.sv
module fsd_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] q;

  generate
    if (STAGES == 1) begin : gOne
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= '0;
        else       q <= din;
      end
    end else begin : gMany
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= '0;
        else       q <= {q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = q[STAGES-1];
endmodule

// File: rtl/fsd_ctrl.sv
module fsd_ctrl
  import fsd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       carrierSel,
  input  logic [3:0] progBits,
  input  logic       syncPol,
  input  logic       extSync,
  output modeCfgT    cfg,
  output strobeT     strobe
);
  logic [MODE_W-1:0] modeIn;
  logic [MODE_W-1:0] modeQ;
  logic              syncSeen;
  logic              syncPrev;
  logic              activeNow;
  logic              activePrev;

  assign modeIn = {carrierSel, progBits};

  fsd_sync_chain #(.STAGES(SYNC_STAGES)) uSync (
    .clk  (clk),
    .rstN (rstN),
    .din  (extSync),
    .dout (syncSeen)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPrev <= 1'b0;
      modeQ    <= '0;
    end else begin
      syncPrev <= syncSeen;
      modeQ    <= modeIn;
    end
  end

  assign activeNow      = syncSeen ^ syncPol;
  assign activePrev     = syncPrev ^ syncPol;
  assign strobe.realign = activeNow & ~activePrev;
  assign strobe.restart = (modeIn != modeQ);
  assign cfg            = decodeMode(modeQ);

  AST_SINGLE_REALIGN: assert property (@(posedge clk) disable iff (!rstN)
    strobe.realign |=> !strobe.realign); // R8

  AST_MODE_SETTLES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |=> (modeQ == $past(modeIn))); // R9
endmodule

// File: rtl/fsd_datapath.sv
module fsd_datapath
  import fsd_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  modeCfgT cfg,
  input  strobeT  strobe,
  input  logic    syncPol,
  output logic    divClk,
  output logic    frameSync
);
  logic [PHASE_W-1:0] divPhase;
  logic [FRAME_W-1:0] frameCnt;
  logic [PHASE_W-1:0] highLen;
  logic [PHASE_W-1:0] halfLen;
  logic               phaseWrap;
  logic               frameWrap;
  logic               pulseOn;
  logic               zeroAll;

  assign zeroAll   = strobe.realign | strobe.restart;
  assign phaseWrap = (divPhase == cfg.ratio - PHASE_W'(1));
  assign frameWrap = (frameCnt == cfg.frameLen - FRAME_W'(1));
  assign highLen   = (cfg.ratio + PHASE_W'(1)) >> 1;
  assign halfLen   = cfg.ratio >> 1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divPhase <= '0;
      frameCnt <= '0;
    end else if (zeroAll) begin
      divPhase <= '0;
      frameCnt <= '0;
    end else if (phaseWrap) begin
      divPhase <= '0;
      frameCnt <= frameWrap ? '0 : frameCnt + FRAME_W'(1);
    end else begin
      divPhase <= divPhase + PHASE_W'(1);
    end
  end

  assign divClk    = (divPhase < highLen);
  assign pulseOn   = (frameCnt == '0) && (!cfg.shortPulse || (divPhase < halfLen));
  assign frameSync = pulseOn ^ syncPol;

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.restart |-> (divPhase < cfg.ratio)); // R2

  AST_FRAME_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.restart |-> (frameCnt < cfg.frameLen)); // R3

  AST_REALIGN_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobe.realign |=> (divPhase == '0 && frameCnt == '0)); // R7

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |=> (divPhase == '0 && frameCnt == '0)); // R9

  AST_FRAME_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (phaseWrap && !frameWrap && !zeroAll) |=>
      (frameCnt == $past(frameCnt) + FRAME_W'(1))); // R3
endmodule

// File: rtl/frame_sync_divider.sv
module frame_sync_divider
  import fsd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       fastClk,
  input  logic       rstN,
  input  logic       carrierSel,
  input  logic [3:0] progBits,
  input  logic       syncPol,
  input  logic       extSync,
  output logic       divClk,
  output logic       frameSync
);
  modeCfgT cfg;
  strobeT  strobe;

  fsd_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk        (fastClk),
    .rstN       (rstN),
    .carrierSel (carrierSel),
    .progBits   (progBits),
    .syncPol    (syncPol),
    .extSync    (extSync),
    .cfg        (cfg),
    .strobe     (strobe)
  );

  fsd_datapath uData (
    .clk       (fastClk),
    .rstN      (rstN),
    .cfg       (cfg),
    .strobe    (strobe),
    .syncPol   (syncPol),
    .divClk    (divClk),
    .frameSync (frameSync)
  );
endmodule

// File: tb/sim_frame_sync_divider.sv
`timescale 1ns/1ps
module sim_frame_sync_divider;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sel = 1'b0;
  logic [3:0] prog = 4'd0;
  logic       pol = 1'b0;
  logic       ext = 1'b0;
  logic       divClk;
  logic       frameSync;

  int    checks = 0;
  int    errors = 0;
  int    cycleCount = 0;
  string reqTag = "R2";

  always #2 clk = ~clk;

  frame_sync_divider u0 (
    .fastClk(clk), .rstN(rstN), .carrierSel(sel), .progBits(prog),
    .syncPol(pol), .extSync(ext), .divClk(divClk), .frameSync(frameSync)
  );

  // Rates in kHz taken from the requirement tables.
  function automatic int divRate(input logic s, input logic [3:0] p);
    if (!s) begin
      if (p == 4 || p == 6 || p == 12 || p == 14) return 2560;
      if (p == 5 || p == 9 || p == 11 || p == 13 || p == 15) return 4096;
      return 2048;
    end
    if (p == 4 || p == 6 || p == 12 || p == 14) return 1544;
    if (p == 2 || p == 3 || p == 7 || p == 11 || p == 15) return 1544;
    return 3088;
  endfunction

  function automatic int fastRate(input logic s, input logic [3:0] p);
    if (!s) begin
      if (p == 4 || p == 6 || p == 12 || p == 14) return 7680;
      if (p == 0 || p == 2 || p == 8 || p == 10) return 6144;
      return 8192;
    end
    if (p == 4 || p == 6 || p == 12 || p == 14) return 7720;
    return 6176;
  endfunction

  function automatic int expRatio(input logic [4:0] m);
    return fastRate(m[4], m[3:0]) / divRate(m[4], m[3:0]);
  endfunction

  function automatic int expLen(input logic [4:0] m);
    return divRate(m[4], m[3:0]) / 8;
  endfunction

  function automatic bit expShort(input logic [4:0] m);
    return !m[4] && (m[3:0] == 1 || m[3:0] == 3 || m[3:0] == 7);
  endfunction

  // Cycle reference model built from R2..R9
  int         mPhase, mFrame, mR, mL;
  logic [4:0] mMode;
  logic       mS1, mS2, mS3, mEdge, mChg;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPhase = 0; mFrame = 0; mMode = 5'd0;
      mS1 = 0; mS2 = 0; mS3 = 0;
    end else begin
      mR    = expRatio(mMode);
      mL    = expLen(mMode);
      mEdge = (mS2 ^ pol) && !(mS3 ^ pol);
      mChg  = ({sel, prog} != mMode);
      if (mChg || mEdge) begin
        mPhase = 0; mFrame = 0;
      end else if (mPhase == mR - 1) begin
        mPhase = 0;
        mFrame = (mFrame == mL - 1) ? 0 : mFrame + 1;
      end else begin
        mPhase = mPhase + 1;
      end
      mS3 = mS2; mS2 = mS1; mS1 = ext; mMode = {sel, prog};
    end
  end

  function automatic logic modelDiv();
    int r = expRatio(mMode);
    return mPhase < (r + 1) / 2;
  endfunction

  function automatic logic modelSync();
    int r = expRatio(mMode);
    logic on = (mFrame == 0) && (!expShort(mMode) || mPhase < r / 2);
    return on ^ pol;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Advance n cycles; compare against the model at every falling edge.
  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check("R2 divClk", divClk, modelDiv());
      check({reqTag, " frameSync"}, frameSync, modelSync());
    end
  endtask

  task automatic setMode(input logic s, input logic [3:0] p);
    sel = s; prog = p;
  endtask

  // Cycles from now until the next leading edge of an active pulse.
  task automatic nextPulse(output int cyc);
    logic prev = 1'b1;
    cyc = 0;
    for (int i = 0; i < 3000; i++) begin
      prev = frameSync ^ pol;
      step(1);
      cyc++;
      if ((frameSync ^ pol) && !prev) break;
    end
  endtask

  task automatic pulseWidth(output int w);
    int dummy;
    nextPulse(dummy);
    w = 1;
    for (int i = 0; i < 16; i++) begin
      step(1);
      if (!(frameSync ^ pol)) break;
      w++;
    end
  endtask

  always @(posedge clk) begin
    cycleCount++;
    if (cycleCount > 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=done", cycleCount);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int per, w, seedVal;
    seedVal = $urandom(32'd20251);
    // R1 reset state
    #1;
    @(negedge clk);
    check("R1 divClk", divClk, 1);
    check("R1 frameSync", frameSync, 1);
    @(negedge clk);
    rstN = 1'b1;
    step(20);

    // R9 mode change restarts counters
    reqTag = "R9";
    setMode(1'b0, 4'd5);
    step(7);
    setMode(1'b1, 4'd4);
    step(1);
    check("R9 divClk after change", divClk, 1);
    check("R9 frameSync after change", frameSync, 1);

    // R3 period, ratio 5 length 193
    reqTag = "R3";
    nextPulse(per);
    nextPulse(per);
    check("R3 period sel1 p4", per, 5 * 193);
    setMode(1'b0, 4'd13);
    nextPulse(per);
    nextPulse(per);
    check("R3 period sel0 p13", per, 2 * 512);

    // R4/R5 pulse widths
    reqTag = "R5";
    setMode(1'b0, 4'd1);
    pulseWidth(w);
    check("R4 R5 short width", w, 2);
    setMode(1'b1, 4'd2);
    pulseWidth(w);
    check("R5 long width", w, 4);
    setMode(1'b0, 4'd6);
    pulseWidth(w);
    check("R5 long width ratio3", w, 3);

    // R6 polarity inverted
    reqTag = "R6";
    pol = 1'b1; ext = 1'b1;
    step(1);
    setMode(1'b0, 4'd0);
    nextPulse(per);
    check("R6 active-low level", frameSync, 0);
    step(200);

    // R7 realign latency, active-low external sync
    reqTag = "R7";
    ext = 1'b0;
    step(1);
    ext = 1'b1;
    step(2);
    step(1);
    check("R7 divClk at phase zero", divClk, 1);
    check("R7 frame start", frameSync, 0);
    step(100);
    pol = 1'b0; ext = 1'b0;
    step(50);
    // R7 with active-high sync mid-frame
    ext = 1'b1;
    step(3);
    check("R7 frame start high", frameSync, 1);

    // R8 held level: no repeated realignment
    reqTag = "R8";
    step(300);
    nextPulse(per);
    nextPulse(per);
    check("R8 free-run period while held", per, 3 * 256);
    ext = 1'b0;
    step(2500);

    // Random modes, polarity and subrate pulses
    for (int it = 0; it < 16; it++) begin
      reqTag = "R8 random";
      setMode(1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)));
      pol = 1'($urandom_range(0, 1));
      ext = pol;
      for (int c = 0; c < 2400; c++) begin
        if ($urandom_range(0, 399) == 0) ext = ~pol;
        else if ($urandom_range(0, 3) == 0) ext = pol;
        step(1);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule